// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 16 KB data cache with one way per set. It sits between a processor's load/store port and a word-wide memory bus. Loads and stores that hit complete from the array without touching the bus. Misses evict the resident line, writing it back if it is dirty, and then refill the line with an 8-beat read burst. While a miss is serviced the processor side sees `busy`.

Three maintenance operations are provided besides plain loads and stores. An allocating store takes ownership of a line without reading memory, which makes fast block copies possible. A discard operation drops a line, dirty or not, and sends nothing to the bus. A purge writes a dirty line out and then drops it. A line has one dirty bit. After an allocating store, the words of that line that were not written hold unspecified values, and the whole line counts as dirty.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, `busy` and `rvalid` are low and no bus request is active. Dirty data held before a reset is dropped without a writeback.
- R2: Geometry is 512 lines of 32 bytes. Address bits [4:2] pick the word, bits [13:5] pick the line and bits [31:14] form the tag. Two addresses that are 16 KB apart map to the same line.
- R3: A load that hits raises `rvalid` with the word on `rdata` in the cycle after it is accepted. `busy` stays low and there is no bus traffic.
- R4: A store (`req_op`=1) that hits updates the word in place, marks the line dirty and produces no bus traffic.
- R5: A load (`req_op`=0) or store that misses writes back the victim as 8 beats if the victim is valid and dirty, and writes nothing if it is not. It then reads the new line as one 8-beat burst. A store merges its word after the refill.
- R6: An allocating store (`req_op`=2) that misses never issues a read. It first writes back a dirty victim, then installs the line as valid and dirty with the stored word. If it hits, it behaves like a store hit.
- R7: A discard (`req_op`=3) that hits clears the line with no writeback, even when the line is dirty. A discard that misses changes nothing.
- R8: A purge (`req_op`=4) of a dirty resident line writes the line back as 8 beats and then invalidates it. A purge of a clean line, or one that misses, writes nothing.
- R9: On both burst channels, a valid held without ready keeps its address and data stable. Every burst starts at the line base and steps by 4 bytes for each beat, in word order, for 8 beats.
- R10: `busy` is high from the cycle after a missing request is accepted until that request completes. Requests are accepted only while `busy` is low, and the bus is quiet whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_op | input | 3 | 0 load, 1 store, 2 allocating store, 3 discard, 4 purge |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Cache occupied with a miss or writeback |
| rvalid | output | 1 | Load data valid pulse |
| rdata | output | 32 | Load data |
| mem_wvalid | output | 1 | Write beat valid |
| mem_waddr | output | 32 | Write beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_wready | input | 1 | Write beat accepted |
| mem_arvalid | output | 1 | Line read request valid |
| mem_araddr | output | 32 | Line base address for read |
| mem_arready | input | 1 | Line read request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The checker assumes the following of the environment: requests arrive only while `busy` is low, read beats arrive only after a read request has been accepted, and read beats come in groups of exactly eight. The bench's memory responder accepts one line request at a time and returns exactly eight beats for it. It stalls the ready and valid lines on fixed cycle patterns, so that the hold properties see back-pressure on every burst. Stimulus presents one request for a single cycle and waits for that request to complete before it presents the next.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int DC_ADDR_W     = 32;
    localparam int DC_WORD_W     = 32;
    localparam int DC_LINE_WORDS = 8;
    localparam int DC_LINES      = 512;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ALLOC = 3'd2,
        OP_INVAL = 3'd3,
        OP_PURGE = 3'd4
    } dc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_AR,
        ST_FILL,
        ST_FIN
    } dc_state_e;

    typedef struct packed {
        dc_op_e                 op;
        logic [DC_ADDR_W-1:0]   addr;
        logic [DC_WORD_W-1:0]   wdata;
    } dc_req_t;

    // Operations that need the new line's contents from memory.
    function automatic logic needs_fill(dc_op_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int LINES = 512,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
    parameter int LINES      = 512,
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int DEPTH     = LINES * LINE_WORDS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W     = DC_ADDR_W,
    parameter int WORD_W     = DC_WORD_W,
    parameter int LINES      = DC_LINES,
    parameter int LINE_WORDS = DC_LINE_WORDS,
    localparam int IDX_W     = $clog2(LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = WSEL_W + 2,
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int DAW       = IDX_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  dc_req_t           req,
    output logic              busy,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    // tag array
    output logic [IDX_W-1:0]  tag_idx,
    input  logic              tag_valid,
    input  logic              tag_dirty,
    input  logic [TAG_W-1:0]  tag_rd,
    output logic              tag_we,
    output logic              tag_wvalid,
    output logic              tag_wdirty,
    output logic [TAG_W-1:0]  tag_wtag,
    // data array
    output logic [DAW-1:0]    dat_raddr,
    input  logic [WORD_W-1:0] dat_rdata,
    output logic              dat_we,
    output logic [DAW-1:0]    dat_waddr,
    output logic [WORD_W-1:0] dat_wdata,
    // memory bus
    output logic              mem_wvalid,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_wready,
    output logic              mem_arvalid,
    output logic [ADDR_W-1:0] mem_araddr,
    input  logic              mem_arready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    dc_state_e          state_q, state_d;
    dc_req_t            req_q;
    dc_req_t            cur;
    logic [WSEL_W-1:0]  beat_q;
    logic               beat_adv;
    logic               load_ret;
    logic [WORD_W-1:0]  rdata_q;
    logic               rvalid_q;

    logic [IDX_W-1:0]   cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [WSEL_W-1:0]  cur_word;
    logic               hit;
    logic               victim_dirty;
    logic               accept;

    assign cur      = (state_q == ST_IDLE) ? req : req_q;
    assign cur_idx  = cur.addr[OFF_W +: IDX_W];
    assign cur_tag  = cur.addr[ADDR_W-1 -: TAG_W];
    assign cur_word = cur.addr[2 +: WSEL_W];

    assign tag_idx      = cur_idx;
    assign hit          = tag_valid && (tag_rd == cur_tag);
    assign victim_dirty = tag_valid && tag_dirty;
    assign accept       = req_valid && (state_q == ST_IDLE);

    assign dat_raddr  = (state_q == ST_WB) ? {cur_idx, beat_q} : {cur_idx, cur_word};

    assign mem_wvalid  = (state_q == ST_WB);
    assign mem_waddr   = {tag_rd, cur_idx, beat_q, 2'b00};
    assign mem_wdata   = dat_rdata;
    assign mem_arvalid = (state_q == ST_AR);
    assign mem_araddr  = {cur_tag, cur_idx, {OFF_W{1'b0}}};

    always_comb begin
        state_d    = state_q;
        load_ret   = 1'b0;
        beat_adv   = 1'b0;
        tag_we     = 1'b0;
        tag_wvalid = 1'b0;
        tag_wdirty = 1'b0;
        tag_wtag   = cur_tag;
        dat_we     = 1'b0;
        dat_waddr  = {cur_idx, cur_word};
        dat_wdata  = cur.wdata;

        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (req.op)
                        OP_LOAD: begin
                            if (hit) load_ret = 1'b1;
                            else     state_d  = victim_dirty ? ST_WB : ST_AR;
                        end
                        OP_STORE: begin
                            if (hit) begin
                                dat_we     = 1'b1;
                                tag_we     = 1'b1;
                                tag_wvalid = 1'b1;
                                tag_wdirty = 1'b1;
                            end else begin
                                state_d = victim_dirty ? ST_WB : ST_AR;
                            end
                        end
                        OP_ALLOC: begin
                            if (hit || !victim_dirty) begin
                                dat_we     = 1'b1;
                                tag_we     = 1'b1;
                                tag_wvalid = 1'b1;
                                tag_wdirty = 1'b1;
                            end else begin
                                state_d = ST_WB;
                            end
                        end
                        OP_INVAL: begin
                            if (hit) begin
                                tag_we   = 1'b1;
                                tag_wtag = tag_rd;
                            end
                        end
                        OP_PURGE: begin
                            if (hit) begin
                                if (tag_dirty) begin
                                    state_d = ST_WB;
                                end else begin
                                    tag_we   = 1'b1;
                                    tag_wtag = tag_rd;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_WB: begin
                if (mem_wready) begin
                    beat_adv = 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        state_d = needs_fill(req_q.op) ? ST_AR : ST_FIN;
                    end
                end
            end
            ST_AR: begin
                if (mem_arready) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    beat_adv  = 1'b1;
                    dat_we    = 1'b1;
                    dat_waddr = {cur_idx, beat_q};
                    dat_wdata = mem_rdata;
                    if (beat_q == LAST_BEAT) begin
                        tag_we     = 1'b1;
                        tag_wvalid = 1'b1;
                        state_d    = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
                case (req_q.op)
                    OP_LOAD: load_ret = 1'b1;
                    OP_STORE, OP_ALLOC: begin
                        dat_we     = 1'b1;
                        tag_we     = 1'b1;
                        tag_wvalid = 1'b1;
                        tag_wdirty = 1'b1;
                    end
                    OP_PURGE: begin
                        tag_we   = 1'b1;
                        tag_wtag = tag_rd;
                    end
                    default: ;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            req_q    <= '0;
        end else begin
            state_q  <= state_d;
            rvalid_q <= load_ret;
            if (load_ret) rdata_q <= dat_rdata;
            if (accept)   req_q   <= req;
            if (beat_adv) beat_q  <= beat_q + WSEL_W'(1);
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dc_pkg::*;
#(
    parameter int ADDR_W     = DC_ADDR_W,
    parameter int WORD_W     = DC_WORD_W,
    parameter int LINES      = DC_LINES,
    parameter int LINE_WORDS = DC_LINE_WORDS,
    localparam int IDX_W     = $clog2(LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int TAG_W     = ADDR_W - IDX_W - WSEL_W - 2,
    localparam int DAW       = IDX_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    output logic              mem_wvalid,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_wready,
    output logic              mem_arvalid,
    output logic [ADDR_W-1:0] mem_araddr,
    input  logic              mem_arready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);

    dc_req_t            req;
    logic [IDX_W-1:0]   tag_idx;
    logic               tag_valid, tag_dirty;
    logic [TAG_W-1:0]   tag_rd;
    logic               tag_we, tag_wvalid, tag_wdirty;
    logic [TAG_W-1:0]   tag_wtag;
    logic [DAW-1:0]     dat_raddr, dat_waddr;
    logic [WORD_W-1:0]  dat_rdata, dat_wdata;
    logic               dat_we;

    assign req.op    = dc_op_e'(req_op);
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;

    dc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (tag_idx),
        .rd_valid (tag_valid),
        .rd_dirty (tag_dirty),
        .rd_tag   (tag_rd),
        .we       (tag_we),
        .wr_idx   (tag_idx),
        .wr_valid (tag_wvalid),
        .wr_dirty (tag_wdirty),
        .wr_tag   (tag_wtag)
    );

    dc_data_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) i_data (
        .clk     (clk),
        .rd_addr (dat_raddr),
        .rd_data (dat_rdata),
        .we      (dat_we),
        .wr_addr (dat_waddr),
        .wr_data (dat_wdata)
    );

    dc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
    ) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req         (req),
        .busy        (busy),
        .rvalid      (rvalid),
        .rdata       (rdata),
        .tag_idx     (tag_idx),
        .tag_valid   (tag_valid),
        .tag_dirty   (tag_dirty),
        .tag_rd      (tag_rd),
        .tag_we      (tag_we),
        .tag_wvalid  (tag_wvalid),
        .tag_wdirty  (tag_wdirty),
        .tag_wtag    (tag_wtag),
        .dat_raddr   (dat_raddr),
        .dat_rdata   (dat_rdata),
        .dat_we      (dat_we),
        .dat_waddr   (dat_waddr),
        .dat_wdata   (dat_wdata),
        .mem_wvalid  (mem_wvalid),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .mem_wready  (mem_wready),
        .mem_arvalid (mem_arvalid),
        .mem_araddr  (mem_araddr),
        .mem_arready (mem_arready),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata)
    );

endmodule

// File: rtl/dc_checker.sv
module dc_checker
    import dc_pkg::*;
#(
    parameter int ADDR_W     = DC_ADDR_W,
    parameter int WORD_W     = DC_WORD_W,
    parameter int LINE_WORDS = DC_LINE_WORDS,
    localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              busy,
    input logic              rvalid,
    input logic              mem_wvalid,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_wready,
    input logic              mem_arvalid,
    input logic [ADDR_W-1:0] mem_araddr,
    input logic              mem_arready
);

    logic              alloc_q;
    logic [WSEL_W-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_q <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            if (req_valid && !busy) alloc_q <= (req_op == 3'(OP_ALLOC));
            else if (!busy)         alloc_q <= 1'b0;
            if (mem_wvalid && mem_wready) wcnt_q <= wcnt_q + WSEL_W'(1);
        end
    end

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wvalid && !mem_arvalid)); // R10

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_arvalid && !mem_arready) |=> (mem_arvalid && $stable(mem_araddr))); // R9

    AST_W_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata))); // R9

    AST_WBURST_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (wcnt_q == '0)); // R9

    AST_INVAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == 3'(OP_INVAL)) |=> (!busy && !mem_wvalid)); // R7

    AST_ALLOC_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        alloc_q |-> !mem_arvalid); // R6

    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !busy); // R3

endmodule

bind dcache_wb dc_checker #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
) i_dc_checker (.*);

// File: tb/test_dcache_wb.sv
module test_dcache_wb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] LD = 3'd0;
    localparam logic [2:0] ST = 3'd1;
    localparam logic [2:0] AL = 3'd2;
    localparam logic [2:0] IV = 3'd3;
    localparam logic [2:0] PG = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  rdb;
        logic [3:0]  wrb;
        logic [3:0]  reqn;
    } vec_t;

    localparam int NVEC = 32;
    localparam vec_t VEC [NVEC] = '{
        '{LD, 32'h0000_0100, 32'h0,         32'h5A5A_0100, 4'd1, 4'd0, 4'd5},  // R5 clean miss
        '{LD, 32'h0000_0104, 32'h0,         32'h5A5A_0104, 4'd0, 4'd0, 4'd3},  // R3 hit
        '{ST, 32'h0000_0108, 32'h1111_2222, 32'h0,         4'd0, 4'd0, 4'd4},  // R4
        '{LD, 32'h0000_0108, 32'h0,         32'h1111_2222, 4'd0, 4'd0, 4'd4},  // R4
        '{LD, 32'h0000_4100, 32'h0,         32'h5A5A_4100, 4'd1, 4'd8, 4'd5},  // R5 dirty victim
        '{LD, 32'h0000_0108, 32'h0,         32'h1111_2222, 4'd1, 4'd0, 4'd5},  // R5
        '{ST, 32'h0000_0204, 32'hCAFE_0001, 32'h0,         4'd1, 4'd0, 4'd5},  // R5 store miss
        '{LD, 32'h0000_0208, 32'h0,         32'h5A5A_0208, 4'd0, 4'd0, 4'd5},  // R5 merge kept fill
        '{LD, 32'h0000_0204, 32'h0,         32'hCAFE_0001, 4'd0, 4'd0, 4'd5},  // R5
        '{AL, 32'h0000_4204, 32'hBEEF_0002, 32'h0,         4'd0, 4'd8, 4'd6},  // R6 dirty victim
        '{LD, 32'h0000_4204, 32'h0,         32'hBEEF_0002, 4'd0, 4'd0, 4'd6},  // R6
        '{IV, 32'h0000_4204, 32'h0,         32'h0,         4'd0, 4'd0, 4'd7},  // R7 dirty dropped
        '{LD, 32'h0000_4204, 32'h0,         32'h5A5A_4204, 4'd1, 4'd0, 4'd7},  // R7 never reached memory
        '{LD, 32'h0000_0204, 32'h0,         32'hCAFE_0001, 4'd1, 4'd0, 4'd6},  // R6 victim written
        '{ST, 32'h0000_0200, 32'h7777_0003, 32'h0,         4'd0, 4'd0, 4'd4},  // R4
        '{PG, 32'h0000_0200, 32'h0,         32'h0,         4'd0, 4'd8, 4'd8},  // R8 dirty purge
        '{PG, 32'h0000_0200, 32'h0,         32'h0,         4'd0, 4'd0, 4'd8},  // R8 miss
        '{LD, 32'h0000_0200, 32'h0,         32'h7777_0003, 4'd1, 4'd0, 4'd8},  // R8 invalidated
        '{PG, 32'h0000_0200, 32'h0,         32'h0,         4'd0, 4'd0, 4'd8},  // R8 clean purge
        '{AL, 32'h0000_0300, 32'h1234_0004, 32'h0,         4'd0, 4'd0, 4'd6},  // R6 no fetch
        '{LD, 32'h0000_0300, 32'h0,         32'h1234_0004, 4'd0, 4'd0, 4'd6},  // R6
        '{IV, 32'h0000_4300, 32'h0,         32'h0,         4'd0, 4'd0, 4'd7},  // R7 miss
        '{LD, 32'h0000_0300, 32'h0,         32'h1234_0004, 4'd0, 4'd0, 4'd7},  // R7 untouched
        '{AL, 32'h0000_4304, 32'h9999_0005, 32'h0,         4'd0, 4'd8, 4'd6},  // R6
        '{LD, 32'h0000_0300, 32'h0,         32'h1234_0004, 4'd1, 4'd8, 4'd6},  // R6 line dirty
        '{LD, 32'h0000_4304, 32'h0,         32'h9999_0005, 4'd1, 4'd0, 4'd6},  // R6
        '{AL, 32'h0000_4308, 32'h5555_0006, 32'h0,         4'd0, 4'd0, 4'd6},  // R6 hit
        '{LD, 32'h0000_4308, 32'h0,         32'h5555_0006, 4'd0, 4'd0, 4'd6},  // R6
        '{ST, 32'h0000_3FFC, 32'hAAAA_0007, 32'h0,         4'd1, 4'd0, 4'd2},  // R2 last line
        '{LD, 32'h0000_3FE0, 32'h0,         32'h5A5A_3FE0, 4'd0, 4'd0, 4'd2},  // R2
        '{LD, 32'h0000_7FFC, 32'h0,         32'h5A5A_7FFC, 4'd1, 4'd8, 4'd2},  // R2 alias
        '{LD, 32'h0000_3FFC, 32'h0,         32'hAAAA_0007, 4'd1, 4'd0, 4'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rvalid;
    logic [31:0] rdata;
    logic        mem_wvalid, mem_arvalid;
    logic [31:0] mem_waddr, mem_wdata, mem_araddr;
    logic        mem_wready = 1'b0;
    logic        mem_arready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_wb i_dcache_wb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rvalid(rvalid), .rdata(rdata), .mem_wvalid(mem_wvalid),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
        .mem_arvalid(mem_arvalid), .mem_araddr(mem_araddr),
        .mem_arready(mem_arready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model
    logic [31:0] mem [logic [31:0]];
    int cyc = 0;
    int pend = 0;
    int wpos = 0;
    int rd_bursts = 0;
    int wr_beats = 0;
    int addr_err = 0;
    logic [31:0] rbase = '0;
    logic [31:0] wbase = '0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    always @(negedge clk) begin
        cyc++;
        mem_arready = 1'b0;
        mem_rvalid  = 1'b0;
        mem_wready  = 1'b0;
        if (rst) begin
            pend = 0;
            wpos = 0;
        end else begin
            if (mem_wvalid && (cyc % 3 != 1)) begin
                mem_wready = 1'b1;
                if (wpos == 0) begin
                    wbase = mem_waddr;
                    if (mem_waddr[4:0] != 5'd0) addr_err++;
                end else if (mem_waddr != wbase + 32'(wpos * 4)) begin
                    addr_err++;
                end
                mem[mem_waddr] = mem_wdata;
                wr_beats++;
                wpos = (wpos + 1) % 8;
            end
            if (pend == 0 && mem_arvalid && (cyc % 2 == 0)) begin
                mem_arready = 1'b1;
                rbase = mem_araddr;
                if (mem_araddr[4:0] != 5'd0) addr_err++;
                pend = 8;
                rd_bursts++;
            end else if (pend > 0 && (cyc % 4 != 3)) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_rd(rbase + 32'((8 - pend) * 4));
                pend--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] q, output int ncyc, output logic busy1);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        ncyc  = 1;
        busy1 = busy;
        q     = '0;
        if (op == LD) begin
            while (!rvalid) begin @(negedge clk); ncyc++; end
            q = rdata;
        end else begin
            while (busy) begin @(negedge clk); ncyc++; end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] q;
        int ncyc, rb0, wb0;
        logic b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 bus", {30'd0, mem_wvalid, mem_arvalid}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            rb0 = rd_bursts; wb0 = wr_beats;
            do_op(VEC[i].op, VEC[i].addr, VEC[i].wdata, q, ncyc, b1);
            if (VEC[i].op == LD)
                chk($sformatf("R%0d vec%0d data", VEC[i].reqn, i), q, VEC[i].exp);
            chk($sformatf("R%0d vec%0d reads", VEC[i].reqn, i), 32'(rd_bursts - rb0), 32'(VEC[i].rdb));
            chk($sformatf("R%0d vec%0d wbeats", VEC[i].reqn, i), 32'(wr_beats - wb0), 32'(VEC[i].wrb));
        end

        // R3 hit latency: 0x3FFC resident
        rb0 = rd_bursts;
        do_op(LD, 32'h0000_3FFC, 32'h0, q, ncyc, b1);
        chk("R3 latency", 32'(ncyc), 32'd1);
        chk("R3 busy low", {31'd0, b1}, 32'd0);

        // R10 busy on miss (clean victim, tag 2 at line 511)
        do_op(LD, 32'h0000_BFFC, 32'h0, q, ncyc, b1);
        chk("R10 busy after miss", {31'd0, b1}, 32'd1);
        chk("R10 miss data", q, 32'h5A5A_BFFC);

        // R1 reset drops dirty data without writeback
        do_op(ST, 32'h0000_BFF8, 32'hDEAD_0008, q, ncyc, b1);
        wb0 = wr_beats;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        rb0 = rd_bursts;
        do_op(LD, 32'h0000_BFF8, 32'h0, q, ncyc, b1);
        chk("R1 refetch", 32'(rd_bursts - rb0), 32'd1);
        chk("R1 dirty dropped", q, 32'h5A5A_BFF8);
        chk("R1 no writeback", 32'(wr_beats - wb0), 32'd0);

        // R9 burst addressing
        chk("R9 addr order", 32'(addr_err), 32'd0);
        chk("R9 whole bursts", 32'(wr_beats % 8), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule